// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This unit sits between the execute stage of a little-endian 32-bit load/store core and a word-wide data memory. It turns a load or store request into aligned memory traffic and the data to write back. For sub-word loads it picks the addressed byte or halfword lane and extends it to 32 bits. For the four partial-word operations it merges memory bytes with either the old register value (left/right loads) or the old memory word (left/right stores). The byte shift for these merges is the address offset within the word times eight.

A request is a single-cycle pulse with `req_valid`, taken only while `req_ready` is high. Reads go out in the same cycle the request is taken. The memory returns the word one cycle later. The unit drives the register write-back port one cycle after that. Byte, halfword and word stores write with byte strobes one cycle after acceptance. Left/right stores are a read-modify-write: the unit reads the aligned word, holds the returned word for one cycle, then writes the merged word with all strobes set.

Top module: `unaligned_merge_unit`

## Requirements
- R1: Every memory read and write address has its two low bits cleared. Left/right loads and stores read the word at the effective address with bits [1:0] zeroed, and left/right stores write back to that same word.
- R2: Op codes 0 (signed byte) and 2 (signed halfword) sign-extend to 32 bits. Op codes 1 (unsigned byte) and 3 (unsigned halfword) zero-extend. The byte is lane addr[1:0]. The halfword is bits [31:16] when addr[1] is 1 and bits [15:0] otherwise.
- R3: Op code 4 (word load) returns the whole aligned memory word, whatever the offset.
- R4: Op code 5 (left load) gives old register byte i where i < 3-off. For i >= 3-off it gives memory byte i-(3-off). At offset 3 the memory word replaces the register entirely.
- R5: Op code 6 (right load) gives memory byte i+off where i <= 3-off, and old register byte i elsewhere. At offset 0 the memory word replaces the register entirely.
- R6: Op code 11 (left store) writes register byte j+3-off into memory byte j where j <= off, and keeps the old memory byte elsewhere. The full-strobe write comes two cycles after acceptance.
- R7: Op code 12 (right store) writes register byte j-off into memory byte j where j >= off, and keeps the old memory byte elsewhere.
- R8: Op codes 8, 9 and 10 (byte, halfword and word store) issue no read. They write one cycle after acceptance.
  - A byte store uses strobe 1<<off and places register bits [7:0] in that lane.
  - A halfword store uses strobe 4'b1100 when addr[1] is 1 and 4'b0011 otherwise, and places register bits [15:0] there.
  - A word store uses strobe 4'b1111.
- R9: A load whose destination index is 0 still issues its memory read but produces no write-back.
- R10: After reset `req_ready` is 1 and no read, write or write-back is active. A load with a nonzero destination drives `wb_valid`, `wb_idx` and `wb_data` exactly two cycles after the edge on which it is accepted.
- R11: Op codes 7, 13, 14 and 15 are ignored: no read, no write, no write-back, and `req_ready` stays high.
- R12: `req_ready` is low for one cycle after a byte, halfword or word store is accepted, and for two cycles after a left/right store. Requests presented while it is low are ignored. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse |
| req_op | input | 4 | Operation code (see requirements) |
| req_addr | input | ADDR_W | Effective byte address |
| req_dst | input | IDX_W | Destination register index for loads |
| req_reg | input | 32 | Old target register value (loads) or store source (stores) |
| req_ready | output | 1 | Unit can take a request this cycle |
| mem_rd_en | output | 1 | Aligned read strobe |
| mem_raddr | output | ADDR_W | Aligned read address |
| mem_rdata | input | 32 | Read word, valid one cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Write strobe |
| mem_waddr | output | ADDR_W | Aligned write address |
| mem_wstrb | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write word |
| wb_valid | output | 1 | Register write-back valid |
| wb_idx | output | IDX_W | Write-back register index |
| wb_data | output | 32 | Write-back value |

## Verification
Reads are due combinationally in the cycle a request is presented. Write-back data is due two edges after acceptance. Byte, halfword and word store writes are due one edge after acceptance, and left/right store writes two edges after. The bench drives a request at a falling edge and then samples at each following falling edge. At each of those edges it checks only the output due there. Stored results are checked in the bench memory one cycle after the write. `req_ready` is checked once the busy window has closed. Expected values come from byte-by-byte bench functions written from the requirements rather than from shift masks.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [3:0] {
    OP_LD_S8  = 4'd0,
    OP_LD_U8  = 4'd1,
    OP_LD_S16 = 4'd2,
    OP_LD_U16 = 4'd3,
    OP_LD_W   = 4'd4,
    OP_LD_HI  = 4'd5,
    OP_LD_LO  = 4'd6,
    OP_ST_8   = 4'd8,
    OP_ST_16  = 4'd9,
    OP_ST_W   = 4'd10,
    OP_ST_HI  = 4'd11,
    OP_ST_LO  = 4'd12
  } lsm_op_e;

  function automatic logic op_is_load(input lsm_op_e op);
    return op inside {OP_LD_S8, OP_LD_U8, OP_LD_S16, OP_LD_U16, OP_LD_W, OP_LD_HI, OP_LD_LO};
  endfunction

  function automatic logic op_is_plain_store(input lsm_op_e op);
    return op inside {OP_ST_8, OP_ST_16, OP_ST_W};
  endfunction

  function automatic logic op_is_merge_store(input lsm_op_e op);
    return op inside {OP_ST_HI, OP_ST_LO};
  endfunction
endpackage

// File: rtl/lsm_rst_sync.sv
module lsm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/lsm_load_merge.sv
module lsm_load_merge
  import lsm_pkg::*;
(
  input  lsm_op_e           op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  lane [LANES];
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic [4:0]  sh;
  logic [4:0]  sh_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = mem_word[8*g +: 8];
  end

  always_comb begin
    sh       = {off, 3'b000};
    sh_c     = 5'd24 - sh;
    byte_sel = lane[off];
    half_sel = off[1] ? mem_word[31:16] : mem_word[15:0];
    unique case (op)
      OP_LD_S8:  result = {{24{byte_sel[7]}}, byte_sel};
      OP_LD_U8:  result = {24'd0, byte_sel};
      OP_LD_S16: result = {{16{half_sel[15]}}, half_sel};
      OP_LD_U16: result = {16'd0, half_sel};
      OP_LD_HI:  result = (old_val & (32'h00FF_FFFF >> sh)) | (mem_word << sh_c);
      OP_LD_LO:  result = (old_val & (32'hFFFF_FF00 << sh_c)) | (mem_word >> sh);
      default:   result = mem_word;
    endcase
  end
endmodule

// File: rtl/lsm_store_merge.sv
module lsm_store_merge
  import lsm_pkg::*;
(
  input  logic              left,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] merged
);
  logic [4:0] sh;
  logic [4:0] sh_c;

  always_comb begin
    sh   = {off, 3'b000};
    sh_c = 5'd24 - sh;
    if (left) merged = (src >> sh_c) | (mem_word & (32'hFFFF_FF00 << sh));
    else      merged = (src << sh)   | (mem_word & (32'h00FF_FFFF >> sh_c));
  end
endmodule

// File: rtl/lsm_lane_place.sv
module lsm_lane_place
  import lsm_pkg::*;
(
  input  lsm_op_e           op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  strb,
  output logic [DATA_W-1:0] data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb[g] = (op == OP_ST_8  && off == OFF_W'(g)) ||
                     (op == OP_ST_16 && off[1] == 1'(g / 2)) ||
                     (op == OP_ST_W);
    assign data[8*g +: 8] = (op == OP_ST_8)  ? src[7:0] :
                            (op == OP_ST_16) ? src[8*(g%2) +: 8] :
                                               src[8*g +: 8];
  end
endmodule

// File: rtl/unaligned_merge_unit.sv
module unaligned_merge_unit
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W-1:0]  req_dst,
  input  logic [31:0]       req_reg,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [31:0]       mem_rdata,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [3:0]        mem_wstrb,
  output logic [31:0]       mem_wdata,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [31:0]       wb_data
);
  logic rst_q_n;

  lsm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  // stage 1: accepted request
  logic              s1_vld_q;
  lsm_op_e           s1_op_q;
  logic [OFF_W-1:0]  s1_off_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [IDX_W-1:0]  s1_dst_q;
  logic [DATA_W-1:0] s1_reg_q;
  // stage 2: merge store holding its returned word
  logic              s2_vld_q;
  logic              s2_left_q;
  logic [OFF_W-1:0]  s2_off_q;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [DATA_W-1:0] s2_reg_q;
  logic [DATA_W-1:0] s2_mem_q;
  // write-back register
  logic              wb_vld_q;
  logic [IDX_W-1:0]  wb_idx_q;
  logic [DATA_W-1:0] wb_data_q;

  lsm_op_e           req_op_e;
  logic              op_known;
  logic              accept;
  logic              s2_load;
  logic              wb_load;
  logic [ADDR_W-1:0] req_aligned;
  logic [DATA_W-1:0] ld_result;
  logic [DATA_W-1:0] st_merged;
  logic [DATA_W-1:0] pl_data;
  logic [LANES-1:0]  pl_strb;

  lsm_load_merge u_ld (
    .op(s1_op_q), .off(s1_off_q), .old_val(s1_reg_q),
    .mem_word(mem_rdata), .result(ld_result)
  );

  lsm_lane_place u_pl (
    .op(s1_op_q), .off(s1_off_q), .src(s1_reg_q),
    .strb(pl_strb), .data(pl_data)
  );

  lsm_store_merge u_st (
    .left(s2_left_q), .off(s2_off_q), .src(s2_reg_q),
    .mem_word(s2_mem_q), .merged(st_merged)
  );

  // next-state logic
  always_comb begin
    req_op_e    = lsm_op_e'(req_op);
    op_known    = op_is_load(req_op_e) || op_is_plain_store(req_op_e) ||
                  op_is_merge_store(req_op_e);
    req_ready   = rst_q_n && !(s1_vld_q && !op_is_load(s1_op_q)) && !s2_vld_q;
    accept      = req_valid && req_ready && op_known;
    req_aligned = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    s2_load     = s1_vld_q && op_is_merge_store(s1_op_q);
    wb_load     = s1_vld_q && op_is_load(s1_op_q) && (s1_dst_q != '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_vld_q  <= 1'b0;
      s1_op_q   <= OP_LD_W;
      s1_off_q  <= '0;
      s1_addr_q <= '0;
      s1_dst_q  <= '0;
      s1_reg_q  <= '0;
      s2_vld_q  <= 1'b0;
      s2_left_q <= 1'b0;
      s2_off_q  <= '0;
      s2_addr_q <= '0;
      s2_reg_q  <= '0;
      s2_mem_q  <= '0;
      wb_vld_q  <= 1'b0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else begin
      s1_vld_q <= accept;
      if (accept) begin
        s1_op_q   <= req_op_e;
        s1_off_q  <= req_addr[OFF_W-1:0];
        s1_addr_q <= req_aligned;
        s1_dst_q  <= req_dst;
        s1_reg_q  <= req_reg;
      end
      s2_vld_q <= s2_load;
      if (s2_load) begin
        s2_left_q <= (s1_op_q == OP_ST_HI);
        s2_off_q  <= s1_off_q;
        s2_addr_q <= s1_addr_q;
        s2_reg_q  <= s1_reg_q;
        s2_mem_q  <= mem_rdata;
      end
      wb_vld_q <= wb_load;
      if (wb_load) begin
        wb_idx_q  <= s1_dst_q;
        wb_data_q <= ld_result;
      end
    end
  end

  // outputs
  always_comb begin
    mem_rd_en = accept && (op_is_load(req_op_e) || op_is_merge_store(req_op_e));
    mem_raddr = req_aligned;
    mem_wr_en = s2_vld_q || (s1_vld_q && op_is_plain_store(s1_op_q));
    mem_waddr = s2_vld_q ? s2_addr_q : s1_addr_q;
    mem_wstrb = s2_vld_q ? {LANES{1'b1}} : pl_strb;
    mem_wdata = s2_vld_q ? st_merged : pl_data;
    wb_valid  = wb_vld_q;
    wb_idx    = wb_idx_q;
    wb_data   = wb_data_q;
  end
endmodule

// File: rtl/unaligned_merge_unit_chk.sv
module unaligned_merge_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [3:0]        req_op,
  input logic [IDX_W-1:0]  req_dst,
  input logic              req_ready,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_raddr,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [3:0]        mem_wstrb,
  input logic              wb_valid,
  input logic [IDX_W-1:0]  wb_idx
);
  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_raddr[1:0] == 2'b00); // R1
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_waddr[1:0] == 2'b00); // R1
  AST_MERGE_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && (req_op == 4'd11 || req_op == 4'd12), 2)
      |-> (mem_wr_en && mem_wstrb == 4'hF)); // R6
  AST_NO_WB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx != '0); // R9
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && req_op <= 4'd6 && req_dst != '0, 2) |-> wb_valid); // R10
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 4'd7 || req_op >= 4'd13)) |-> !mem_rd_en); // R11
  AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !mem_rd_en); // R12
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R12
endmodule

bind unaligned_merge_unit unaligned_merge_unit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_dst(req_dst),
  .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_raddr(mem_raddr),
  .mem_wr_en(mem_wr_en), .mem_waddr(mem_waddr), .mem_wstrb(mem_wstrb),
  .wb_valid(wb_valid), .wb_idx(wb_idx)
);

// File: tb/unaligned_merge_unit_bench.sv
`timescale 1ns/1ps
module unaligned_merge_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = 4'd0;
  logic [31:0] req_addr = 32'd0;
  logic [4:0]  req_dst = 5'd0;
  logic [31:0] req_reg = 32'd0;
  logic        req_ready, mem_rd_en, mem_wr_en, wb_valid;
  logic [31:0] mem_raddr, mem_waddr, mem_wdata, wb_data;
  logic [31:0] mem_rdata = 32'd0;
  logic [3:0]  mem_wstrb;
  logic [4:0]  wb_idx;
  logic [31:0] mem [16];
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  unaligned_merge_unit u_unaligned_merge_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_dst(req_dst), .req_reg(req_reg), .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_wr_en(mem_wr_en), .mem_waddr(mem_waddr), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always @(posedge clk) begin
    if (mem_wr_en)
      for (int b = 0; b < 4; b++)
        if (mem_wstrb[b]) mem[mem_waddr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_rd_en) mem_rdata <= mem[mem_raddr[5:2]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byt(input logic [31:0] w, input int i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [31:0] exp_load(input logic [3:0] op, input logic [1:0] off,
                                           input logic [31:0] oldv, input logic [31:0] mw);
    logic [31:0] r;
    logic [7:0] b;
    logic [15:0] h;
    b = byt(mw, off);
    h = {byt(mw, {off[1], 1'b1}), byt(mw, {off[1], 1'b0})};
    case (op)
      4'd0: r = b[7] ? {24'hFFFFFF, b} : {24'h0, b};
      4'd1: r = {24'h0, b};
      4'd2: r = h[15] ? {16'hFFFF, h} : {16'h0, h};
      4'd3: r = {16'h0, h};
      4'd5: for (int i = 0; i < 4; i++)
              r[8*i +: 8] = (i >= 3 - off) ? byt(mw, i - (3 - off)) : byt(oldv, i);
      4'd6: for (int i = 0; i < 4; i++)
              r[8*i +: 8] = (i <= 3 - off) ? byt(mw, i + off) : byt(oldv, i);
      default: r = mw;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] exp_strb(input logic [3:0] op, input logic [1:0] off);
    if (op == 4'd8) return 4'b0001 << off;
    if (op == 4'd9) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_store(input logic [3:0] op, input logic [1:0] off,
                                            input logic [31:0] rv, input logic [31:0] mw);
    logic [31:0] r;
    logic [3:0] s;
    r = mw;
    case (op)
      4'd11: for (int j = 0; j < 4; j++) if (j <= off) r[8*j +: 8] = byt(rv, j + 3 - off);
      4'd12: for (int j = 0; j < 4; j++) if (j >= off) r[8*j +: 8] = byt(rv, j - off);
      default: begin
        s = exp_strb(op, off);
        for (int j = 0; j < 4; j++)
          if (s[j]) r[8*j +: 8] = (op == 4'd8) ? rv[7:0] : (op == 4'd9) ? byt(rv, j % 2) : byt(rv, j);
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: return "R2";
      4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd11: return "R6";
      4'd12: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [31:0] addr,
                        input logic [4:0] dst, input logic [31:0] rv);
    logic [31:0] mw, al;
    logic [1:0] off;
    int w;
    bit ld, ms;
    w = addr[5:2]; off = addr[1:0]; mw = mem[w];
    al = {addr[31:2], 2'b00};
    ld = (op <= 4'd6); ms = (op == 4'd11 || op == 4'd12);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_dst = dst; req_reg = rv;
    #1;
    chk(req_ready == 1'b1, "R10", {31'd0, req_ready}, 32'd1);
    if (ld || ms) chk(mem_rd_en && mem_raddr == al, "R1", mem_raddr, al);
    else chk(!mem_rd_en, "R8", {31'd0, mem_rd_en}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (!ld && !ms)
      chk(mem_wr_en && mem_waddr == al && mem_wstrb == exp_strb(op, off), "R8",
          {mem_waddr[31:4], mem_wstrb}, {al[31:4], exp_strb(op, off)});
    @(negedge clk);
    #1;
    if (ld) begin
      if (dst != 5'd0)
        chk(wb_valid && wb_idx == dst && wb_data == exp_load(op, off, rv, mw),
            tag_of(op), wb_data, exp_load(op, off, rv, mw));
      else
        chk(!wb_valid, "R9", {31'd0, wb_valid}, 32'd0);
    end
    if (ms) chk(mem_wr_en && mem_waddr == al && mem_wstrb == 4'hF, "R1", mem_waddr, al);
    @(negedge clk);
    #1;
    if (!ld) chk(mem[w] == exp_store(op, off, rv, mw), tag_of(op), mem[w], exp_store(op, off, rv, mw));
    chk(req_ready == 1'b1, "R12", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] ops [12];
    logic [31:0] keep;
    void'($urandom(32'd20240611));
    ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12};
    for (int i = 0; i < 16; i++) mem[i] = 32'h8070_6050 + 32'h0101_0101 * i;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    // R10 reset state
    chk(req_ready && !mem_rd_en && !mem_wr_en && !wb_valid, "R10",
        {28'd0, req_ready, mem_rd_en, mem_wr_en, wb_valid}, 32'h8);

    // directed: every offset of the four merge ops and sub-word loads
    mem[0] = 32'h4433_2211;
    for (int a = 0; a < 4; a++) begin
      run_op(4'd5, a, 5'd3, 32'hDDCC_BBAA);
      run_op(4'd6, a, 5'd3, 32'hDDCC_BBAA);
      run_op(4'd0, 32'h10 + a, 5'd4, 32'd0);
      run_op(4'd2, 32'h10 + a, 5'd4, 32'd0);
      mem[1] = 32'h4433_2211;
      run_op(4'd11, 32'h4 + a, 5'd0, 32'hDDCC_BBAA);
      mem[2] = 32'h4433_2211;
      run_op(4'd12, 32'h8 + a, 5'd0, 32'hDDCC_BBAA);
      run_op(4'd8, 32'hC + a, 5'd0, 32'h1234_56F0);
    end
    run_op(4'd4, 32'h0000_0003, 5'd9, 32'd0);
    run_op(4'd1, 32'h0000_0002, 5'd0, 32'd0); // R9 destination zero

    // R11 unknown op codes are ignored
    for (int k = 0; k < 4; k++) begin
      keep = mem[3];
      @(negedge clk);
      req_valid = 1'b1; req_op = (k == 0) ? 4'd7 : 4'd12 + k; req_addr = 32'hC; req_dst = 5'd3;
      req_reg = 32'hFFFF_FFFF;
      #1;
      chk(!mem_rd_en && req_ready, "R11", {30'd0, mem_rd_en, req_ready}, 32'd1);
      @(negedge clk); req_valid = 1'b0; #1;
      chk(!mem_wr_en && req_ready, "R11", {30'd0, mem_wr_en, req_ready}, 32'd1);
      @(negedge clk); #1;
      chk(!wb_valid && mem[3] == keep, "R11", mem[3], keep);
    end

    // R12 requests while busy are ignored
    mem[5] = 32'h0BAD_F00D;
    @(negedge clk);
    req_valid = 1'b1; req_op = 4'd11; req_addr = 32'h17; req_dst = 5'd0; req_reg = 32'h1122_3344;
    @(negedge clk);
    req_op = 4'd4; req_addr = 32'h14; req_dst = 5'd7; #1;
    chk(!req_ready && !mem_rd_en, "R12", {30'd0, req_ready, mem_rd_en}, 32'd0);
    @(negedge clk); #1;
    chk(!req_ready && !mem_rd_en && mem_wr_en, "R12", {29'd0, req_ready, mem_rd_en, mem_wr_en}, 32'd1);
    req_valid = 1'b0;
    @(negedge clk); #1;
    chk(!wb_valid && req_ready, "R12", {30'd0, wb_valid, req_ready}, 32'd1);
    chk(mem[5] == 32'h1122_3344, "R6", mem[5], 32'h1122_3344);
    @(negedge clk); #1;
    chk(!wb_valid, "R12", {31'd0, wb_valid}, 32'd0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      ra = $urandom;
      run_op(ops[$urandom_range(0, 11)], ra, ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom),
             $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule